// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small 16-bit accumulator machine that is run by a microprogram. It holds a control store of 54 microwords. Each microword is 34 bits wide: the upper 28 bits are control lines, one line per bit, and the lower 6 bits name the next microaddress. A 6-bit microaddress register selects the current microword. The control lines of that word are presented combinationally for exactly one clock, and on each rising edge the register moves to the next address.

Every instruction starts with a shared fetch sequence. The last fetch word carries a reserved all-ones next-address code. That code makes the sequencer build the entry address by placing two one bits in front of the 4-bit opcode from the instruction register. Each instruction routine ends with a word whose next address is 0, which returns control to fetch. The datapath, the memory and the instruction register sit outside the block; the only input it takes from them is the opcode.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 without waiting for a clock edge, and `ctrl` shows the first fetch word (28'h0000003).
- R2: Starting from address 0, the fetch sequence steps through 0, 1, 2, 3 on successive edges. The control lines are: at 0, bits 0 (PC onto bus) and 1 (load memory address); at 1, bits 2 (memory read) and 4 (PC increment); at 2, bits 5 (data register onto bus) and 6 (load instruction register); at 3, none.
- R3: On the edge that ends address 3, `upc` becomes 48 plus the opcode value present at that edge. The opcode has no effect on the sequence in any other cycle.
- R4: Opcode 0 (store) runs addresses 48, 4, 5. The control lines are {7 address field onto bus, 1}, then {9 accumulator onto bus, 8 load data register}, then {3 memory write}.
- R5: Opcode 1 (add) runs 48+1, 6, 7, 8. The control lines are {7,1}, {2}, {5, 17 load operand B}, {11 ALU add, 10 load accumulator}.
- R6: Opcode 2 (subtract) runs 50, 9, 10, 11. The control lines have the same shape as R5, with bit 12 in place of bit 11.
- R7: Opcode 3 (and) runs 51, 12, 13, 14. The control lines have the same shape as R5, with bit 13 in place of bit 11.
- R8: Opcode 4 (or) runs 52, 15, 16, 17. The control lines have the same shape as R5, with bit 14 in place of bit 11.
- R9: Opcode 5 (shift left) runs 53, 18. The control lines are {9, 16 load operand A}, then {15 ALU shift, 10}.
- R10: After the last word of any routine, the next address is 0.
- R11: Opcodes 6 to 15 dispatch to addresses 54 to 63. Those addresses lie outside the store: they assert no control line and are followed by address 0.
- R12: At most one of the ALU function bits 11 to 15 is high in any cycle, and memory read (bit 2) and memory write (bit 3) are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field from the instruction register |
| ctrl | output | 28 | Control lines of the current microword |
| upc | output | 6 | Current microaddress |

## Verification
The case that is hardest to reach from the ports is an opcode that changes on the very edge where dispatch takes place. The dispatch must capture the value present at that one edge and ignore every earlier and later value. The bench drives a fresh random opcode on every cycle, so each dispatch edge sees a value that differs from the ones around it, and routines keep running while the opcode input changes under them. Directed passes hold each of the 16 opcodes steady, which also covers the out-of-store addresses 54 to 63. A reset asserted in the middle of a routine checks the asynchronous return to address 0.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int OPW   = 4,
  parameter int UAW   = 6,
  parameter int CTLW  = 28,
  parameter int DEPTH = 54
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  opcode,
  output logic [CTLW-1:0] ctrl,
  output logic [UAW-1:0]  upc
);
  localparam int WORDW = CTLW + UAW;
  localparam int DISP  = (1 << UAW) - 1;

  localparam logic [CTLW-1:0] PC_OUT   = CTLW'(1) << 0;
  localparam logic [CTLW-1:0] MAR_LD   = CTLW'(1) << 1;
  localparam logic [CTLW-1:0] MEM_RD   = CTLW'(1) << 2;
  localparam logic [CTLW-1:0] MEM_WR   = CTLW'(1) << 3;
  localparam logic [CTLW-1:0] PC_INC   = CTLW'(1) << 4;
  localparam logic [CTLW-1:0] MDR_OUT  = CTLW'(1) << 5;
  localparam logic [CTLW-1:0] IR_LD    = CTLW'(1) << 6;
  localparam logic [CTLW-1:0] ADDR_OUT = CTLW'(1) << 7;
  localparam logic [CTLW-1:0] MDR_LD   = CTLW'(1) << 8;
  localparam logic [CTLW-1:0] ACC_OUT  = CTLW'(1) << 9;
  localparam logic [CTLW-1:0] ACC_LD   = CTLW'(1) << 10;
  localparam logic [CTLW-1:0] F_ADD    = CTLW'(1) << 11;
  localparam logic [CTLW-1:0] F_SUB    = CTLW'(1) << 12;
  localparam logic [CTLW-1:0] F_AND    = CTLW'(1) << 13;
  localparam logic [CTLW-1:0] F_OR     = CTLW'(1) << 14;
  localparam logic [CTLW-1:0] F_SHL    = CTLW'(1) << 15;
  localparam logic [CTLW-1:0] OPA_LD   = CTLW'(1) << 16;
  localparam logic [CTLW-1:0] OPB_LD   = CTLW'(1) << 17;

  function automatic logic [WORDW-1:0] uw(input logic [CTLW-1:0] c, input int n);
    return {c, UAW'(n)};
  endfunction

  function automatic logic [WORDW-1:0] rom(input int a);
    case (a)
      0:  return uw(PC_OUT | MAR_LD, 1);
      1:  return uw(MEM_RD | PC_INC, 2);
      2:  return uw(MDR_OUT | IR_LD, 3);
      3:  return uw('0, DISP);
      48: return uw(ADDR_OUT | MAR_LD, 4);
      4:  return uw(ACC_OUT | MDR_LD, 5);
      5:  return uw(MEM_WR, 0);
      49: return uw(ADDR_OUT | MAR_LD, 6);
      6:  return uw(MEM_RD, 7);
      7:  return uw(MDR_OUT | OPB_LD, 8);
      8:  return uw(F_ADD | ACC_LD, 0);
      50: return uw(ADDR_OUT | MAR_LD, 9);
      9:  return uw(MEM_RD, 10);
      10: return uw(MDR_OUT | OPB_LD, 11);
      11: return uw(F_SUB | ACC_LD, 0);
      51: return uw(ADDR_OUT | MAR_LD, 12);
      12: return uw(MEM_RD, 13);
      13: return uw(MDR_OUT | OPB_LD, 14);
      14: return uw(F_AND | ACC_LD, 0);
      52: return uw(ADDR_OUT | MAR_LD, 15);
      15: return uw(MEM_RD, 16);
      16: return uw(MDR_OUT | OPB_LD, 17);
      17: return uw(F_OR | ACC_LD, 0);
      53: return uw(ACC_OUT | OPA_LD, 18);
      18: return uw(F_SHL | ACC_LD, 0);
      default: return uw('0, 0);
    endcase
  endfunction

  logic [WORDW-1:0] cstore [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cs
      assign cstore[i] = rom(i);
    end
  endgenerate

  logic [WORDW-1:0] word;
  logic [UAW-1:0]   nxt_f;
  logic [UAW-1:0]   nxt;

  assign word  = (int'(upc) < DEPTH) ? cstore[upc] : '0;
  assign nxt_f = word[UAW-1:0];
  assign nxt   = (nxt_f == UAW'(DISP)) ? {{(UAW-OPW){1'b1}}, opcode} : nxt_f;
  assign ctrl  = word[WORDW-1:UAW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UAW'(0)) |=> (upc == UAW'(1)));

  // R3
  dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UAW'(3)) |=> (upc == {{(UAW-OPW){1'b1}}, $past(opcode)}));

  // R10
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UAW'(5) || upc == UAW'(8) || upc == UAW'(11) ||
     upc == UAW'(14) || upc == UAW'(17) || upc == UAW'(18)) |=> (upc == '0));

  // R11
  oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(upc) >= DEPTH) |-> (ctrl == '0) ##1 (upc == '0));

  // R12
  alu_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl[15:11]));

  // R12
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[2] && ctrl[3]));
endmodule

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic [27:0] ctrl;
  logic [5:0]  upc;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int exp_upc = 0;
  int prev_upc = 0;

  useq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ctrl(ctrl), .upc(upc));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [27:0] b(input int k);
    return 28'(1) << k;
  endfunction

  function automatic logic [27:0] exp_ctrl(input int a);
    case (a)
      0: return b(0) | b(1);
      1: return b(2) | b(4);
      2: return b(5) | b(6);
      48, 49, 50, 51, 52: return b(7) | b(1);
      4: return b(9) | b(8);
      5: return b(3);
      6, 9, 12, 15: return b(2);
      7, 10, 13, 16: return b(5) | b(17);
      8:  return b(11) | b(10);
      11: return b(12) | b(10);
      14: return b(13) | b(10);
      17: return b(14) | b(10);
      53: return b(9) | b(16);
      18: return b(15) | b(10);
      default: return '0;
    endcase
  endfunction

  function automatic int exp_next(input int a, input int op);
    case (a)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 48 + op;
      48: return 4;
      4: return 5;
      49: return 6;
      6: return 7;
      7: return 8;
      50: return 9;
      9: return 10;
      10: return 11;
      51: return 12;
      12: return 13;
      13: return 14;
      52: return 15;
      15: return 16;
      16: return 17;
      53: return 18;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int prev, input int cur);
    if (prev == 3) return "R3";
    if (cur == 0 && prev != 0) return "R10";
    if (cur <= 3) return "R2";
    if (cur >= 54) return "R11";
    case (cur)
      48, 4, 5: return "R4";
      49, 6, 7, 8: return "R5";
      50, 9, 10, 11: return "R6";
      51, 12, 13, 14: return "R7";
      52, 15, 16, 17: return "R8";
      53, 18: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int op);
    string r;
    r = req_of(prev_upc, exp_upc);
    check(r, int'(upc), exp_upc, "upc");
    check(r, int'(ctrl), int'(exp_ctrl(exp_upc)), "ctrl");
    if (exp_upc == 2) check("R12", int'(ctrl[3:2]), 0, "rd/wr overlap");
    opcode = 4'(op);
    prev_upc = exp_upc;
    exp_upc = exp_next(exp_upc, op);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    #1;
    // R1: reset state
    check("R1", int'(upc), 0, "upc in reset");
    check("R1", int'(ctrl), 3, "ctrl in reset");
    repeat (3) @(negedge clk);
    check("R1", int'(upc), 0, "upc held in reset");
    rst_n = 1'b1;
    exp_upc = 0;
    prev_upc = 0;
    for (int op = 0; op < 16; op++) begin
      repeat (8) step(op);
    end
    for (int i = 0; i < 1500; i++) begin
      step(int'($urandom_range(0, 15)));
    end
    for (int i = 0; i < 6; i++) step(1);
    rst_n = 1'b0;
    #1;
    check("R1", int'(upc), 0, "upc after mid-run reset");
    check("R1", int'(ctrl), 3, "ctrl after mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    exp_upc = 0;
    prev_upc = 0;
    for (int i = 0; i < 200; i++) begin
      step(int'($urandom_range(0, 5)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule